// File: doc/BRIEF.md
# SPI Flash Short-Command Shifter

This block runs short register-style transactions against a serial NOR flash: an opcode, perhaps a few address or parameter bytes, and perhaps a few response bytes. Reading the device identifier, setting write enable and starting a sector erase are typical uses. Software loads a bank of byte-wide program registers and a bit count. It then writes a command code. The block drives one chip-select window of up to 48 serial clocks and captures the flash output line into a bank of byte-wide capture registers. When the window closes, the command register returns to zero, which is the completion flag that software polls.

Two fixed commands sit next to the generic one. The status-read command reads one status byte into its own register. The status-write command sends one byte taken from the top program register. For both, the block supplies the flash opcode itself. The serial link runs in mode 0 on a single data line. The serial clock half-period is a fixed number of system clocks, set by a parameter.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and every readable register returns 0x00.
- R2: Register map with the default parameters: addresses 0..5 hold program bytes P0..P5, address 6 holds the bit count, address 7 is the command register, addresses 8..13 hold capture bytes C0..C5 (read only), and address 14 holds the status byte (read only). Other addresses read 0x00.
- R3: Writing 0x04 to the command register starts a generic transaction of count bits. The transaction sends P5 first and then P4, P3 and so on downward, each byte MSB first. The link uses mode 0: the data out line changes only while the serial clock is low, and the serial clock idles low when chip select is high.
- R4: In a generic transaction, the flash byte received during slot k (the opcode is slot 0) lands in capture byte C(5-k). Capture bytes past the last shifted slot read 0x00, because all capture bytes are cleared when the command starts.
- R5: The command register reads back the written code while the transaction runs. It reads 0x00 once chip select has gone high again. Chip select is low exactly while the command register is nonzero.
- R6: Writing 0x02 sends opcode 0x05 and then one dummy byte (16 clocks). The byte received in the second slot goes to the status register, and the capture bytes stay unchanged.
- R7: Writing 0x20 sends opcode 0x01 and then P5 (16 clocks), whatever the count register holds.
- R8: A command write while a transaction runs is ignored. A write of any code other than 0x04, 0x02 or 0x20 is ignored. A generic command with a count of 0 is ignored and asserts no chip select.
- R9: A count above 48 is clamped, so a generic transaction never exceeds 48 serial clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sck | output | 1 | Serial clock to flash |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The hardest case to reach is a command write that lands while a transaction is still shifting. The stimulus starts a full 48-bit generic command and writes the status-write code partway through the window. It then confirms that the command register still shows the generic code, that only 48 clocks were issued, and that no second chip-select window follows. Receive-slot mirroring is checked with a behavioural flash model that returns a distinct byte in every slot. A shorter transaction then follows a full one, which shows that capture bytes left over from the earlier transfer are cleared.

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int NBYTES = 6,
  parameter int SCK_HALF = 2,
  parameter int AW = 4,
  parameter logic [7:0] CMD_GEN = 8'h04,
  parameter logic [7:0] CMD_RDST = 8'h02,
  parameter logic [7:0] CMD_WRST = 8'h20,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_WRSR = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  localparam int NBITS = 8 * NBYTES;
  localparam int CW = $clog2(NBITS + 1);
  localparam int IW = $clog2(NBITS);
  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [AW-1:0] A_CNT = AW'(NBYTES);
  localparam logic [AW-1:0] A_CMD = AW'(NBYTES + 1);
  localparam int SH0 = NBYTES + 2;
  localparam logic [AW-1:0] A_STAT = AW'(2 * NBYTES + 2);

  logic [7:0] pd [NBYTES];
  logic [7:0] sh [NBYTES];
  logic [7:0] cnt_q, cmd_q, stat_q;
  logic [NBITS-1:0] pd_flat, tx_q, rx_q;
  logic [CW-1:0] nbits_q, gen_bits;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] div_q;
  logic sck_q, cs_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_flat
    assign pd_flat[8*g +: 8] = pd[g];
  end

  assign gen_bits = (int'(cnt_q) > NBITS) ? CW'(NBITS) : CW'(cnt_q);

  wire busy   = cmd_q != 8'h00;
  wire cmd_wr = wr_en && (wr_addr == A_CMD) && !busy;
  wire st_gen = cmd_wr && (wr_data == CMD_GEN) && (gen_bits != '0);
  wire st_rd  = cmd_wr && (wr_data == CMD_RDST);
  wire st_wr  = cmd_wr && (wr_data == CMD_WRST);
  wire tick   = div_q == DW'(SCK_HALF - 1);
  wire last   = idx_q == IW'(nbits_q - 1'b1);

  assign sck  = sck_q;
  assign cs_n = cs_q;
  assign mosi = tx_q[NBITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < NBYTES; i++) pd[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CNT) cnt_q <= wr_data;
      for (int i = 0; i < NBYTES; i++)
        if (wr_addr == AW'(i)) pd[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0; stat_q <= '0; tx_q <= '0; rx_q <= '0;
      nbits_q <= '0; idx_q <= '0; div_q <= '0;
      sck_q <= 1'b0; cs_q <= 1'b1;
      for (int i = 0; i < NBYTES; i++) sh[i] <= '0;
    end else if (st_gen || st_rd || st_wr) begin
      cmd_q <= wr_data;
      cs_q <= 1'b0; sck_q <= 1'b0;
      div_q <= '0; idx_q <= '0; rx_q <= '0;
      if (st_gen) begin
        tx_q <= pd_flat;
        nbits_q <= gen_bits;
      end else begin
        tx_q <= st_rd ? {OP_RDSR, {(NBITS-8){1'b0}}}
                      : {OP_WRSR, pd[NBYTES-1], {(NBITS-16){1'b0}}};
        nbits_q <= CW'(16);
      end
    end else if (busy) begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q[NBITS-1-int'(idx_q)] <= miso;
        end else begin
          sck_q <= 1'b0;
          if (last) begin
            cs_q <= 1'b1;
            cmd_q <= '0;
            if (cmd_q == CMD_RDST) stat_q <= rx_q[NBITS-9 -: 8];
            else if (cmd_q == CMD_GEN)
              for (int i = 0; i < NBYTES; i++) sh[i] <= rx_q[8*i +: 8];
          end else begin
            idx_q <= idx_q + 1'b1;
            tx_q <= tx_q << 1;
          end
        end
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == A_CNT) rd_data = cnt_q;
    if (rd_addr == A_CMD) rd_data = cmd_q;
    if (rd_addr == A_STAT) rd_data = stat_q;
    for (int i = 0; i < NBYTES; i++) begin
      if (rd_addr == AW'(i)) rd_data = pd[i];
      if (rd_addr == AW'(SH0 + i)) rd_data = sh[i];
    end
  end
endmodule

// File: rtl/spi_cmd_shifter_chk.sv
module spi_cmd_shifter_chk #(
  parameter int NBITS = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic       mosi,
  input logic [7:0] cmd
);
  logic sck_d;
  int unsigned edges;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      edges <= 0;
    end else begin
      sck_d <= sck;
      if (cs_n) edges <= 0;
      else if (sck && !sck_d) edges <= edges + 1;
    end
  end

  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_mosi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
  p_cs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 8'h00) == !cs_n);
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 8'h00 && $past(cmd) != 8'h00) |-> cmd == $past(cmd));
  p_max_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edges <= NBITS);
endmodule

bind spi_cmd_shifter spi_cmd_shifter_chk #(.NBITS(8 * NBYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .cmd(cmd_q)
);

// File: tb/spi_cmd_shifter_test.sv
module spi_cmd_shifter_test;
  logic clk = 0, rst_n = 0, wr_en = 0, miso = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic sck, cs_n, mosi;
  int checks = 0, errors = 0, cs_falls = 0, nb = 0, mode_viol = 0;
  logic [63:0] mo = 0;
  logic [47:0] resp = 0;

  always #2 clk = ~clk;

  spi_cmd_shifter uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always @(negedge cs_n) begin cs_falls++; nb = 0; mo = 0; miso = resp[47]; end
  always @(posedge sck) begin mo = {mo[62:0], mosi}; nb++; end
  always @(negedge sck) if (!cs_n && nb < 48) miso = resp[47-nb];
  always @(mosi) if (!cs_n && sck) mode_viol++;

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: act=hung exp=done");
    finish_sim();
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic wait_done();
    logic [7:0] c;
    for (int i = 0; i < 2000; i++) begin
      rd(4'd7, c);
      if (c == 8'h00) return;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 cs_n", cs_n, 1); chk("R1 sck", sck, 0);
    for (int a = 0; a < 16; a++) begin rd(4'(a), d); chk("R1 reg", d, 0); end
  endtask

  task automatic t_id_read();
    logic [7:0] d;
    for (int i = 0; i < 6; i++) wr(4'(i), 8'h00);
    wr(4'd5, 8'h9F); wr(4'd6, 8'd48);
    resp = 48'h00_C2_20_18_AB_CD;
    wr(4'd7, 8'h04);
    wait_done();
    chk("R3 sent", mo[47:0], 48'h9F00_0000_0000);
    chk("R3 bits", nb, 48);
    chk("R5 cs released", cs_n, 1);
    rd(4'd13, d); chk("R4 C5", d, 8'h00);
    rd(4'd12, d); chk("R4 C4", d, 8'hC2);
    rd(4'd10, d); chk("R4 C2", d, 8'h18);
    rd(4'd8, d);  chk("R4 C0", d, 8'hCD);
    chk("R3 mode", mode_viol, 0);
  endtask

  task automatic t_erase();
    logic [7:0] d;
    wr(4'd5, 8'h20); wr(4'd4, 8'h12); wr(4'd3, 8'h34); wr(4'd2, 8'h56);
    wr(4'd6, 8'd32);
    resp = 48'hA1B2C3D4E5F6;
    wr(4'd7, 8'h04);
    wait_done();
    chk("R3 addr order", mo[31:0], 32'h20123456);
    chk("R3 bits", nb, 32);
    rd(4'd13, d); chk("R4 C5", d, 8'hA1);
    rd(4'd10, d); chk("R4 C2", d, 8'hD4);
    rd(4'd9, d);  chk("R4 C1 cleared", d, 8'h00);
    rd(4'd8, d);  chk("R4 C0 cleared", d, 8'h00);
  endtask

  task automatic t_busy();
    logic [7:0] d;
    int f0;
    wr(4'd6, 8'd48); resp = 48'h0;
    f0 = cs_falls;
    wr(4'd7, 8'h04);
    repeat (20) @(negedge clk);
    rd(4'd7, d); chk("R5 busy readback", d, 8'h04);
    wr(4'd7, 8'h20);
    rd(4'd7, d); chk("R8 busy write ignored", d, 8'h04);
    wait_done();
    repeat (50) @(negedge clk);
    chk("R8 single window", cs_falls - f0, 1);
    chk("R8 bits", nb, 48);
    rd(4'd7, d); chk("R5 done", d, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    resp = 48'h00_5A_0000_0000;
    wr(4'd7, 8'h02);
    wait_done();
    chk("R6 sent", mo[15:0], 16'h0500);
    chk("R6 bits", nb, 16);
    rd(4'd14, d); chk("R6 status", d, 8'h5A);
    rd(4'd13, d); chk("R6 capture kept", d, 8'h00);
    rd(4'd12, d); chk("R6 capture kept", d, 8'h00);
    wr(4'd5, 8'hA7); wr(4'd6, 8'd48);
    wr(4'd7, 8'h20);
    wait_done();
    chk("R7 sent", mo[15:0], 16'h01A7);
    chk("R7 bits", nb, 16);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    int f0;
    wr(4'd5, 8'h9F); wr(4'd6, 8'd60);
    wr(4'd7, 8'h04);
    wait_done();
    chk("R9 clamp", nb, 48);
    f0 = cs_falls;
    wr(4'd6, 8'd0); wr(4'd7, 8'h04);
    rd(4'd7, d); chk("R8 zero count", d, 8'h00);
    wr(4'd6, 8'd8); wr(4'd7, 8'h33);
    rd(4'd7, d); chk("R8 unknown code", d, 8'h00);
    repeat (20) @(negedge clk);
    chk("R8 no window", cs_falls - f0, 0);
    rd(4'd6, d); chk("R2 count readback", d, 8'd8);
    rd(4'd15, d); chk("R2 unmapped", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_id_read();
    t_erase();
    t_busy();
    t_status();
    t_edges();
    finish_sim();
  end
endmodule